// File: doc/BRIEF.md
# Interrupt and Wake Status Controller

This block gathers single-cycle event pulses from four general interrupt sources and one wake (power management) source. Each pulse sets a sticky bit in a five-bit status register. The block combines the status with a five-bit mask register to drive two active-low request pins. The four low bits feed the general interrupt pin. The top bit feeds a separate wake pin, and that pin is independent of the general one.

A host uses a small register port to reach both registers. One select line picks the status register or the mask register. Mask writes take effect on the next clock edge. A status read returns the register contents one cycle later and clears every bit that was returned. Status bits latch whatever the mask holds, so a condition that is recorded while masked raises its pin as soon as the host unmasks it. Both pins come from flops, so they only change on a clock edge.

Top module: `irq_pme_ctrl`

## Requirements
- R1: After reset the status register and mask register are zero, `int_n` and `pme_n` are high, and `host_rdata` is zero.
- R2: A high level on `gen_evt[i]` (bit i, i = 0..3) or on `pme_evt` (bit 4) at a clock edge sets that status bit, whatever the mask holds.
- R3: A read with `host_sel` = 0 (status) and `host_rd` high at edge k puts the status value from before edge k onto `host_rdata` from edge k on. At the same edge it clears every status bit.
- R4: When a source event arrives in the same cycle as a clearing status read, its status bit is set after that edge, so the event is not lost.
- R5: `int_n` is low in the cycle after an edge where any of status bits [3:0] ANDed with mask bits [3:0] is set. Otherwise it is high.
- R6: `pme_n` is low in the cycle after an edge where status bit 4 and mask bit 4 are both set. Otherwise it is high, and it does not depend on bits [3:0].
- R7: A write with `host_sel` = 1 (mask) and `host_wr` high loads `host_wdata` into the mask. A read with `host_sel` = 1 returns the mask and leaves the status unchanged.
- R8: A write with `host_sel` = 0 has no effect on the status register or on the mask register.
- R9: Unmasking a status bit that is already set drives its pin low one cycle after the edge that loads the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| gen_evt | input | 4 | General event pulses, one per source |
| pme_evt | input | 1 | Wake event pulse |
| host_sel | input | 1 | Register select: 0 status, 1 mask |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 5 | Write data |
| host_rdata | output | 5 | Registered read data |
| int_n | output | 1 | General interrupt request, active low |
| pme_n | output | 1 | Wake request, active low |

## Verification
Two functions can fall in the same clock cycle: a new source event setting a status bit, and a host read clearing it. The bench provokes this by sending an event pulse in the same cycle as a status read while other bits are already pending. It then expects the read to return the older value, and a second read to return only the bit that arrived during the first read. A cycle-accurate model in the bench, built from the requirements, also predicts both pins on every cycle of an exhaustive sweep over all mask and event pairs.

// File: rtl/irq_pme_pkg.sv
// Package: shared sizes and the host register select encoding for the
// interrupt and wake controller.
package irq_pme_pkg;
    localparam int GEN_SRC = 4;            // number of general sources
    localparam int STAT_W  = GEN_SRC + 1;  // general bits plus the wake bit

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_MASK   = 1'b1
    } host_sel_e;
endpackage

// File: rtl/irq_stat_bank.sv
// Module: irq_stat_bank
// Holds one sticky status bit per source. An event pulse sets its bit. A
// clear reloads every bit from the events seen in the same cycle, so an
// event that coincides with a clear survives it.
// Assumes events are one-cycle pulses synchronous to clk.
module irq_stat_bank #(
    parameter int W = irq_pme_pkg::STAT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         clr,
    output logic [W-1:0] stat
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Purpose: set on an event, reload from events on a clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stat[i] <= 1'b0;
            else if (clr)
                stat[i] <= evt[i];
            else
                stat[i] <= stat[i] | evt[i];
        end

        assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> stat[i]);
        assert_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && evt[i]) |=> stat[i]);
        assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && !evt[i]) |=> !stat[i]);
        assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (stat[i] && !clr) |=> stat[i]);
    end
endmodule

// File: rtl/irq_mask_bank.sv
// Module: irq_mask_bank
// Mask register that enables each status bit onto its request pin.
// Assumes the caller decodes the write strobe for this register.
module irq_mask_bank #(
    parameter int W = irq_pme_pkg::STAT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask
);
    // Purpose: load the mask on a decoded write, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask <= '0;
        else if (wr_en)
            mask <= wdata;
    end

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask));
    assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mask == $past(wdata)));
endmodule

// File: rtl/irq_pin_drv.sv
// Module: irq_pin_drv
// Drives one active-low request pin from a group of status bits and their
// mask bits. The pin comes from a flop, so it only moves on a clock edge.
// Assumes status and mask are register outputs.
module irq_pin_drv #(
    parameter int N = irq_pme_pkg::GEN_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] stat,
    input  logic [N-1:0] mask,
    output logic         pin_n
);
    logic active;

    // Purpose: any enabled pending bit requests service.
    always_comb active = |(stat & mask);

    // Purpose: register the request and invert it for the active-low pin.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin_n <= 1'b1;
        else
            pin_n <= ~active;
    end

    assert_pin_low_R5_R6: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> !pin_n);
    assert_pin_high_R5_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> pin_n);
endmodule

// File: rtl/irq_host_rd.sv
// Module: irq_host_rd
// Host read path. It returns the selected register one cycle after the
// strobe and requests a status clear when the status register is read.
// Assumes read and write strobes are single-cycle and decoded upstream.
module irq_host_rd #(
    parameter int W = irq_pme_pkg::STAT_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_en,
    input  irq_pme_pkg::host_sel_e sel,
    input  logic [W-1:0]          stat,
    input  logic [W-1:0]          mask,
    output logic                  stat_clr,
    output logic [W-1:0]          rdata
);
    import irq_pme_pkg::*;

    // Purpose: a status read clears the bits it returns.
    always_comb stat_clr = rd_en && (sel == SEL_STATUS);

    // Purpose: capture the selected register on a read and hold it after.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= (sel == SEL_MASK) ? mask : stat;
    end

    assert_rdata_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr |=> (rdata == $past(stat)));
endmodule

// File: rtl/irq_pme_ctrl.sv
// Module: irq_pme_ctrl (top)
// Latches four general events and one wake event into a status register
// that clears on read. A mask register gates the status onto two active-low
// pins: a general interrupt and a separate wake request.
// Assumes a synchronous host port with single-cycle strobes.
module irq_pme_ctrl #(
    parameter int NUM_GEN = irq_pme_pkg::GEN_SRC,
    localparam int W       = NUM_GEN + 1,
    localparam int WAKE_B  = NUM_GEN
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM_GEN-1:0] gen_evt,
    input  logic           pme_evt,
    input  logic           host_sel,
    input  logic           host_wr,
    input  logic           host_rd,
    input  logic [W-1:0]   host_wdata,
    output logic [W-1:0]   host_rdata,
    output logic           int_n,
    output logic           pme_n
);
    import irq_pme_pkg::*;

    host_sel_e    sel;
    logic [W-1:0] evt_all;
    logic [W-1:0] stat;
    logic [W-1:0] mask;
    logic         stat_clr;
    logic         mask_wr;

    // Purpose: gather the event pulses and decode the host strobes.
    always_comb begin
        sel     = host_sel_e'(host_sel);
        evt_all = {pme_evt, gen_evt};
        mask_wr = host_wr && (sel == SEL_MASK);
    end

    irq_stat_bank #(.W(W)) stat_i (
        .clk(clk), .rst_n(rst_n), .evt(evt_all), .clr(stat_clr), .stat(stat));

    irq_mask_bank #(.W(W)) mask_i (
        .clk(clk), .rst_n(rst_n), .wr_en(mask_wr), .wdata(host_wdata),
        .mask(mask));

    irq_host_rd #(.W(W)) rd_i (
        .clk(clk), .rst_n(rst_n), .rd_en(host_rd), .sel(sel), .stat(stat),
        .mask(mask), .stat_clr(stat_clr), .rdata(host_rdata));

    irq_pin_drv #(.N(NUM_GEN)) gen_pin_i (
        .clk(clk), .rst_n(rst_n), .stat(stat[NUM_GEN-1:0]),
        .mask(mask[NUM_GEN-1:0]), .pin_n(int_n));

    irq_pin_drv #(.N(1)) wake_pin_i (
        .clk(clk), .rst_n(rst_n), .stat(stat[WAKE_B]),
        .mask(mask[WAKE_B]), .pin_n(pme_n));

    assert_status_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_rd && sel == SEL_STATUS)
            |=> (stat == ($past(stat) | $past(evt_all))));
    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (int_n && pme_n && mask == '0 && stat == '0));
endmodule

// File: tb/irq_pme_ctrl_tb.sv
// Bench: exhaustive sweep of mask and event pairs checked against a
// cycle-accurate model, plus directed corner cases.
module irq_pme_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] gen_evt;
    logic       pme_evt;
    logic       host_sel, host_wr, host_rd;
    logic [4:0] host_wdata;
    logic [4:0] host_rdata;
    logic       int_n, pme_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [4:0] m_st, m_mk, m_rd;
    logic       m_int_n, m_pme_n;

    always #10 clk = ~clk;

    irq_pme_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .gen_evt(gen_evt), .pme_evt(pme_evt),
        .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .int_n(int_n), .pme_n(pme_n));

    task automatic chk(input string tag, input logic [4:0] act,
                       input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at the falling edge, model the rising edge, check at
    // the next falling edge.
    task automatic cyc(input logic [3:0] g, input logic p, input logic s,
                       input logic w, input logic r, input logic [4:0] wd,
                       input string rtag);
        gen_evt = g; pme_evt = p; host_sel = s; host_wr = w; host_rd = r;
        host_wdata = wd;
        @(posedge clk);
        m_int_n = ~|(m_st[3:0] & m_mk[3:0]);
        m_pme_n = ~(m_st[4] & m_mk[4]);
        if (r) m_rd = s ? m_mk : m_st;
        if (r && !s) m_st = {p, g};
        else         m_st = m_st | {p, g};
        if (w && s)  m_mk = wd;
        @(negedge clk);
        gen_evt = '0; pme_evt = 1'b0; host_wr = 1'b0; host_rd = 1'b0;
        chk("R5 int_n", {4'd0, int_n}, {4'd0, m_int_n});
        chk("R6 pme_n", {4'd0, pme_n}, {4'd0, m_pme_n});
        if (r) chk(rtag, host_rdata, m_rd);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; gen_evt = '0; pme_evt = 1'b0; host_sel = 1'b0;
        host_wr = 1'b0; host_rd = 1'b0; host_wdata = '0;
        m_st = '0; m_mk = '0; m_rd = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1 int_n", {4'd0, int_n}, 5'd1);
        chk("R1 pme_n", {4'd0, pme_n}, 5'd1);
        chk("R1 rdata", host_rdata, 5'd0);
        rst_n = 1'b1;
        cyc(4'h0, 1'b0, 1'b1, 1'b0, 1'b1, 5'd0, "R1 mask after reset");
        cyc(4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0, "R1 status after reset");

        // Exhaustive sweep: every mask against every event pattern (R2 R3 R5 R6 R7)
        for (int mk = 0; mk < 32; mk++) begin
            for (int ev = 0; ev < 32; ev++) begin
                cyc(4'h0, 1'b0, 1'b1, 1'b1, 1'b0, 5'(mk), "");
                cyc(4'(ev), ev[4], 1'b1, 1'b0, 1'b0, 5'd0, "");
                cyc(4'h0, 1'b0, 1'b1, 1'b0, 1'b1, 5'd0, "R7 mask readback");
                cyc(4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0, "R2 R3 status read");
                cyc(4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, "");
                cyc(4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0, "R3 cleared after read");
            end
        end

        // R4: an event coinciding with a clearing read survives it
        cyc(4'h0, 1'b0, 1'b1, 1'b1, 1'b0, 5'h1F, "");
        cyc(4'h6, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, "");
        cyc(4'h1, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0, "R4 read returns older value");
        chk("R4 first read", host_rdata, 5'h16);
        cyc(4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0, "R4 coincident event kept");
        chk("R4 second read", host_rdata, 5'h01);
        cyc(4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, "");
        chk("R4 pins released int_n", {4'd0, int_n}, 5'd1);

        // R8: a write aimed at the status register changes nothing
        cyc(4'h0, 1'b0, 1'b1, 1'b1, 1'b0, 5'h0A, "");
        cyc(4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 5'h1F, "");
        cyc(4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, "");
        chk("R8 int_n stays high", {4'd0, int_n}, 5'd1);
        cyc(4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0, "R8 status unchanged");
        chk("R8 status zero", host_rdata, 5'h00);
        cyc(4'h0, 1'b0, 1'b1, 1'b0, 1'b1, 5'd0, "R8 mask unchanged");
        chk("R8 mask kept", host_rdata, 5'h0A);

        // R9: unmask bits that were latched while masked
        cyc(4'h0, 1'b0, 1'b1, 1'b1, 1'b0, 5'h00, "");
        cyc(4'h8, 1'b1, 1'b1, 1'b0, 1'b0, 5'd0, "");
        cyc(4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0, "");
        chk("R9 masked int_n high", {4'd0, int_n}, 5'd1);
        chk("R9 masked pme_n high", {4'd0, pme_n}, 5'd1);
        cyc(4'h0, 1'b0, 1'b1, 1'b1, 1'b0, 5'h18, "");
        cyc(4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0, "");
        chk("R9 int_n low after unmask", {4'd0, int_n}, 5'd0);
        chk("R9 pme_n low after unmask", {4'd0, pme_n}, 5'd0);

        // R7: a mask read leaves pending status in place
        cyc(4'h0, 1'b0, 1'b1, 1'b0, 1'b1, 5'd0, "R7 mask read");
        cyc(4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0, "R7 status kept after mask read");
        chk("R7 status value", host_rdata, 5'h18);
        cyc(4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, "");
        cyc(4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, "");
        chk("R6 pme_n released", {4'd0, pme_n}, 5'd1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule